// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a word-wide storage register that, on each rising clock edge, keeps its contents, moves them one place toward the high end, moves them one place toward the low end, or captures a full word from its data port. A two-bit select picks the operation. An active-low clear zeroes the word at once, independent of the clock. Each shift direction has its own serial input, and the two end bits are brought out on serial outputs that are always driven, so several of these registers can be chained into a longer word.

The parallel data port is shared between reading and writing. In fabric, where real tri-state pins are not available, the port is split into an input bus, an output bus and a drive-enable. The drive-enable is high only when both output-disable inputs are low and the load operation is not selected, so during a load the external source owns the wires. The disables only gate the drivers; they never change what the register stores.

Top module: `bidir_shift_reg`

## Requirements
- R1: The select `modeSel` is decoded as 2'b00 hold, 2'b01 shift toward the high end, 2'b10 shift toward the low end, 2'b11 parallel load; exactly one operation acts per edge.
- R2: In hold mode the stored word is unchanged by a rising clock edge.
- R3: In shift-up mode (01), a rising edge moves bit i-1 into bit i for every i from 1 to WIDTH-1, and bit 0 takes `serInRight`.
- R4: In shift-down mode (10), a rising edge moves bit i+1 into bit i for every i from 0 to WIDTH-2, and bit WIDTH-1 takes `serInLeft`.
- R5: In load mode (11), a rising edge stores the value on `portIn`.
- R6: While `clrN` is low the stored word is zero, at once and without a clock edge, whatever mode is selected and whether or not edges occur.
- R7: `portDrive` is 1 exactly when `disA` and `disB` are both 0 and `modeSel` is not 2'b11; `portOut` always carries the stored word.
- R8: `disA` and `disB` have no effect on holding, shifting, loading or clearing the stored word.
- R9: `serOutFirst` equals stored bit 0 and `serOutLast` equals stored bit WIDTH-1 at all times, including while the port drivers are disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Asynchronous clear, active low |
| modeSel | input | 2 | Operation select (bit 0 and bit 1 as in R1) |
| disA | input | 1 | Output disable, active high |
| disB | input | 1 | Output disable, active high |
| serInRight | input | 1 | Serial input entering bit 0 on a shift-up |
| serInLeft | input | 1 | Serial input entering bit WIDTH-1 on a shift-down |
| portIn | input | WIDTH | Data seen on the shared port, captured in load mode |
| portOut | output | WIDTH | Stored word presented to the port drivers |
| portDrive | output | 1 | Drive-enable for the shared port |
| serOutFirst | output | 1 | Stored bit 0, always driven |
| serOutLast | output | 1 | Stored bit WIDTH-1, always driven |

## Verification
The clear and a clocked operation can land on the same edge: the bench holds `clrN` low across a rising edge with load selected and all-ones on `portIn`, and expects zero both before and after that edge, then releases clear and expects a normal load on the following edge. Output disabling and shifting also coincide: shifts and loads run with one or both disables high, and the scoreboard expects the stored word, serial outputs and drive-enable to follow R3 to R9 unchanged by the disables.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_SHUP  = 2'b01,
    MODE_SHDN  = 2'b10,
    MODE_LOAD  = 2'b11
  } modeT;

  typedef struct packed {
    logic loadEn;
    logic shUp;
    logic shDown;
  } strobeT;

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       disA,
  input  logic       disB,
  output strobeT     strobes,
  output logic       driveEn
);

  modeT modeNow;

  always_comb begin
    modeNow = modeT'(modeSel);
    strobes = '0;
    unique case (modeNow)
      MODE_HOLD: strobes = '0;
      MODE_SHUP: strobes.shUp = 1'b1;
      MODE_SHDN: strobes.shDown = 1'b1;
      MODE_LOAD: strobes.loadEn = 1'b1;
      default:   strobes = '0;
    endcase
  end

  // Disables only gate drivers; load mode hands the port to the outside.
  assign driveEn = !disA && !disB && !strobes.loadEn;

  // R1: at most one operation strobe per cycle
  always_comb begin
    p_one_mode_r1: assert ($onehot0({strobes.loadEn, strobes.shUp, strobes.shDown}));
  end

endmodule

// File: rtl/bsr_dpath.sv
module bsr_dpath
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clrN,
  input  strobeT           strobes,
  input  logic             serInRight,
  input  logic             serInLeft,
  input  logic [WIDTH-1:0] portIn,
  output logic [WIDTH-1:0] stored
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextWord;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromBelow;
    logic fromAbove;
    if (i == 0) begin : g_low_end
      assign fromBelow = serInRight;
    end else begin : g_low_mid
      assign fromBelow = stored[i-1];
    end
    if (i == TOP) begin : g_high_end
      assign fromAbove = serInLeft;
    end else begin : g_high_mid
      assign fromAbove = stored[i+1];
    end
    assign nextWord[i] = strobes.loadEn ? portIn[i]  :
                         strobes.shUp   ? fromBelow  :
                         strobes.shDown ? fromAbove  :
                                          stored[i];
  end

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) stored <= '0;
    else       stored <= nextWord;
  end

  // R2: hold leaves the word untouched
  p_hold_r2: assert property (@(posedge clk) disable iff (!clrN)
    (strobes == '0) |=> (stored == $past(stored)));

  // R3: shift toward the high end
  p_shift_up_r3: assert property (@(posedge clk) disable iff (!clrN)
    strobes.shUp |=> (stored[0] == $past(serInRight)) &&
                     (stored[TOP:1] == $past(stored[TOP-1:0])));

  // R4: shift toward the low end
  p_shift_down_r4: assert property (@(posedge clk) disable iff (!clrN)
    strobes.shDown |=> (stored[TOP] == $past(serInLeft)) &&
                       (stored[TOP-1:0] == $past(stored[TOP:1])));

  // R5: load captures the port
  p_load_r5: assert property (@(posedge clk) disable iff (!clrN)
    strobes.loadEn |=> (stored == $past(portIn)));

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic [1:0]       modeSel,
  input  logic             disA,
  input  logic             disB,
  input  logic             serInRight,
  input  logic             serInLeft,
  input  logic [WIDTH-1:0] portIn,
  output logic [WIDTH-1:0] portOut,
  output logic             portDrive,
  output logic             serOutFirst,
  output logic             serOutLast
);

  strobeT           strobes;
  logic [WIDTH-1:0] stored;

  bsr_ctrl u_ctrl (
    .modeSel (modeSel),
    .disA    (disA),
    .disB    (disB),
    .strobes (strobes),
    .driveEn (portDrive)
  );

  bsr_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk        (clk),
    .clrN       (clrN),
    .strobes    (strobes),
    .serInRight (serInRight),
    .serInLeft  (serInLeft),
    .portIn     (portIn),
    .stored     (stored)
  );

  assign portOut     = stored;
  assign serOutFirst = stored[0];
  assign serOutLast  = stored[WIDTH-1];

  // R7: drivers never fight an external source during a load
  p_no_drive_load_r7: assert property (@(posedge clk) disable iff (!clrN)
    strobes.loadEn |-> !portDrive);

endmodule

// File: tb/bidir_shift_reg_test.sv
`timescale 1ns/1ps
module bidir_shift_reg_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clrN = 1'b0;
  logic [1:0]   modeSel = 2'b00;
  logic         disA = 1'b0, disB = 1'b0;
  logic         serInRight = 1'b0, serInLeft = 1'b0;
  logic [W-1:0] portIn = '0;
  logic [W-1:0] portOut;
  logic         portDrive, serOutFirst, serOutLast;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [W-1:0] word;
    logic         drive;
    string        tag;
  } expT;

  expT          sb[$];
  logic [W-1:0] model = '0;

  always #2 clk = ~clk;

  bidir_shift_reg #(.WIDTH(W)) uut (
    .clk(clk), .clrN(clrN), .modeSel(modeSel), .disA(disA), .disB(disB),
    .serInRight(serInRight), .serInLeft(serInLeft), .portIn(portIn),
    .portOut(portOut), .portDrive(portDrive),
    .serOutFirst(serOutFirst), .serOutLast(serOutLast)
  );

  task automatic compare(input logic [W-1:0] expWord, input logic expDrive,
                         input string tag);
    total++;
    if (portOut !== expWord || portDrive !== expDrive ||
        serOutFirst !== expWord[0] || serOutLast !== expWord[W-1]) begin
      bad++;
      $display("FAIL %s: word=%h drive=%b first=%b last=%b expected word=%h drive=%b first=%b last=%b",
               tag, portOut, portDrive, serOutFirst, serOutLast,
               expWord, expDrive, expWord[0], expWord[W-1]);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected result.
  task automatic step(input logic [1:0] sel, input logic dA, input logic dB,
                      input logic sr, input logic sl, input logic [W-1:0] pin,
                      input logic clr, input string tag);
    expT e;
    @(negedge clk);
    modeSel = sel; disA = dA; disB = dB;
    serInRight = sr; serInLeft = sl; portIn = pin; clrN = clr;
    if (!clr) model = '0;
    else begin
      case (sel)
        2'b00: model = model;
        2'b01: model = {model[W-2:0], sr};
        2'b10: model = {sl, model[W-1:1]};
        default: model = pin;
      endcase
    end
    e.word  = model;
    e.drive = !dA && !dB && (sel != 2'b11);
    e.tag   = tag;
    sb.push_back(e);
  endtask

  // Monitor: checks each queued item just after the edge it belongs to.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        expT e;
        e = sb.pop_front();
        compare(e.word, e.drive, e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #40000;
    bad++;
    total++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare('0, 1'b1, "R6 reset state");

    step(2'b00, 0, 0, 0, 0, 8'h00, 1, "R2 hold after clear");
    step(2'b11, 0, 0, 0, 0, 8'hA5, 1, "R5 R7 load A5 drivers off");
    step(2'b00, 1, 0, 0, 0, 8'hFF, 1, "R2 R8 hold disA high");
    step(2'b00, 0, 0, 0, 0, 8'h00, 1, "R7 readback enabled");
    step(2'b01, 0, 0, 1, 0, 8'h00, 1, "R1 R3 shift up ser 1");
    step(2'b01, 0, 1, 0, 1, 8'h00, 1, "R3 R8 shift up disB high");
    step(2'b01, 1, 1, 1, 0, 8'h00, 1, "R3 R9 shift up both disabled");
    step(2'b10, 0, 0, 1, 1, 8'h00, 1, "R1 R4 shift down ser 1");
    step(2'b10, 1, 0, 0, 0, 8'h00, 1, "R4 R8 shift down disA high");
    step(2'b11, 0, 1, 0, 0, 8'h81, 1, "R5 R8 load while disabled");
    step(2'b00, 1, 1, 0, 0, 8'h00, 1, "R9 ends visible while disabled");
    for (int k = 0; k < W; k++) step(2'b01, 0, 0, 1, 0, 8'h00, 1, "R3 fill ones");
    for (int k = 0; k < W; k++) step(2'b10, 0, 0, 0, 0, 8'h00, 1, "R4 drain zeros");
    step(2'b11, 0, 0, 0, 0, 8'h3C, 1, "R5 load 3C");

    // R6: clear asserted between edges acts at once
    @(negedge clk);
    #0.5;
    clrN = 1'b0;
    #0.5;
    compare('0, portDrive, "R6 async clear mid cycle");
    model = '0;
    // R6: clear held across an edge with load selected
    step(2'b11, 0, 0, 0, 0, 8'hFF, 0, "R6 clear beats load");
    step(2'b11, 0, 0, 0, 0, 8'h5A, 1, "R5 load after clear release");
    step(2'b01, 1, 0, 0, 0, 8'h00, 0, "R6 R8 clear while disabled");
    step(2'b00, 0, 0, 0, 0, 8'h00, 1, "R2 hold after second clear");

    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule